// File: doc/BRIEF.md
# Dual-Half Ring DMA Address Generator

This block produces word addresses for two circular buffers in shared memory. One ring feeds outgoing data and the other collects incoming data. Each ring is described by three programmable pointers: its first word, the last word of its lower half (the midpoint), and its last word. A per-direction time-slot strobe moves that ring's current address forward by one word. After the last word it returns to the first word.

A four-bit half-free status is derived by comparing each live address against its midpoint pointer. Whenever that status differs from the value last reported, the block raises a one-cycle interrupt pulse, gated by a per-bit enable mask. Software then refills or drains the half that the DMA engine has just left.

Two voice channels share every 32-bit buffer word, each in its own byte lane. A small packer places a channel's byte in its lane and produces the matching byte enables, so a write for one channel never disturbs the other. A register port programs the pointers and control, and reads back the live addresses.

Top module: `hdma_ring_addr`

## Requirements
- R1: After reset the transmit ring spans words 0..511 with midpoint 255, the receive ring spans words 512..639 with midpoint 575, both current addresses sit at their ring start, the control register reads 0xFF, and irq is low.
- R2: While control bit 0 is set, both current addresses are reloaded to their start pointer every cycle and strobes do not move them. Writing 0x40 to the control register releases the engine.
- R3: With the engine released and the enable register's bit 0 at 1, each cycle with tickTx high adds one to txAddr, and each cycle with tickRx high adds one to rxAddr. Each direction ignores the other's strobe.
- R4: A strobe that finds the current address equal to its end pointer loads the start pointer instead of incrementing.
- R5: With the enable register's bit 0 at 0, strobes leave both addresses unchanged.
- R6: halfStatus bit 3 is 1 when rxAddr is below the receive midpoint, and bit 2 is 1 otherwise. Bit 1 is 1 when txAddr is below the transmit midpoint, and bit 0 is 1 otherwise.
- R7: irq is a one-cycle pulse in the cycle after halfStatus differs from the last reported value, provided a differing bit has its mask bit set. The last reported value is held at 0 while the engine is held, so the first cycle after release reports.
- R8: A status change whose differing bits are all masked raises no irq but is still recorded as reported. Re-enabling the mask later does not raise a late pulse.
- R9: laneChan 0 places laneByte in bits 7:0 with laneBe 4'b0001, and laneChan 1 places it in bits 15:8 with laneBe 4'b0010. All other bits of laneData are zero.
- R10: With laneFill high the selected lane carries 0xFF regardless of laneByte.
- R11: The register map, by regAddr:
  - 0: control
  - 1: enable (bit 0)
  - 2: irq mask (bits 3:0)
  - 3: halfStatus (read only)
  - 4, 5, 6: transmit start, midpoint and end
  - 7: live txAddr (read only)
  - 8, 9, 10: receive start, midpoint and end
  - 11: live rxAddr (read only)

  All reads are zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| tickTx | input | 1 | Transmit time-slot strobe |
| tickRx | input | 1 | Receive time-slot strobe |
| txAddr | output | ADDR_W | Current transmit word address |
| rxAddr | output | ADDR_W | Current receive word address |
| halfStatus | output | 4 | Half-free status vector |
| irq | output | 1 | Status-change interrupt pulse |
| laneChan | input | CH_W | Channel selecting the byte lane |
| laneByte | input | 8 | Channel data byte |
| laneFill | input | 1 | Force the idle byte 0xFF |
| laneData | output | 32 | Byte placed in its lane |
| laneBe | output | 4 | Byte enables for laneData |

## Verification
The rings are walked with long single-direction strobe bursts that cross each midpoint and each end. Separate checks show which direction moved, the exact address at which the status flips, and that the wrap lands on the start pointer. Strobes are also applied while the engine is held and while it is disabled, which separates the reload path from the freeze path. A reprogrammed four-word ring is then stepped one strobe at a time, so an off-by-one in the compare or the wrap shows at a single address. Runs with the mask narrowed and then restored tell a recorded-but-silent change apart from a late pulse. Byte packing is driven on both channels with and without the idle fill.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int NDIR = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  // strobes from control to a ring pointer datapath
  typedef struct packed {
    logic reload;
    logic advance;
  } ringStb_t;

  // regAddr[3:2] selects the group, regAddr[1:0] the item inside it
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_TX     = 2'd1,
    GRP_RX     = 2'd2,
    GRP_NONE   = 2'd3
  } regGrp_e;
endpackage

// File: rtl/hdma_ring_ptr.sv
module hdma_ring_ptr
  import hdma_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RST_START = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ringStb_t      stb,
  input  logic [AW-1:0] startPtr,
  input  logic [AW-1:0] endPtr,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= RST_START;
    end else if (stb.reload) begin
      cur <= startPtr;
    end else if (stb.advance) begin
      cur <= (cur == endPtr) ? startPtr : cur + 1'b1;
    end
  end
endmodule

// File: rtl/hdma_ring_ctrl.sv
module hdma_ring_ctrl
  import hdma_pkg::*;
#(
  parameter int AW       = 16,
  parameter int TX_WORDS = 512,
  parameter int RX_WORDS = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [3:0]      regAddr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  input  logic [NDIR-1:0] tick,
  input  logic [AW-1:0]   curAddr [NDIR],
  output ringStb_t        dirStb  [NDIR],
  output logic [AW-1:0]   startPtr[NDIR],
  output logic [AW-1:0]   endPtr  [NDIR],
  output logic [3:0]      status,
  output logic            irq
);
  localparam int RX_BASE = TX_WORDS;

  function automatic logic [AW-1:0] rstStart(input int d);
    return AW'((d == DIR_TX) ? 0 : RX_BASE);
  endfunction
  function automatic logic [AW-1:0] rstMid(input int d);
    return AW'((d == DIR_TX) ? (TX_WORDS / 2 - 1) : (RX_BASE + RX_WORDS / 2 - 1));
  endfunction
  function automatic logic [AW-1:0] rstEnd(input int d);
    return AW'((d == DIR_TX) ? (TX_WORDS - 1) : (RX_BASE + RX_WORDS - 1));
  endfunction

  logic [7:0]    ctrlQ;
  logic          dmaEnQ;
  logic [3:0]    maskQ;
  logic [3:0]    lastQ;
  logic          irqQ;
  logic [AW-1:0] startQ[NDIR];
  logic [AW-1:0] midQ  [NDIR];
  logic [AW-1:0] endQ  [NDIR];
  logic [NDIR-1:0] belowMid;
  logic          holdEng;
  logic          runEng;
  regGrp_e       grp;
  logic          unusedWr;

  assign holdEng  = ctrlQ[0];
  assign runEng   = !holdEng && dmaEnQ;
  assign grp      = regGrp_e'(regAddr[3:2]);
  assign unusedWr = ^regWrData[31:AW];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign belowMid[d]       = curAddr[d] < midQ[d];
    assign dirStb[d].reload  = holdEng;
    assign dirStb[d].advance = runEng && tick[d];
    assign startPtr[d]       = startQ[d];
    assign endPtr[d]         = endQ[d];
  end

  assign status = {belowMid[DIR_RX], !belowMid[DIR_RX],
                   belowMid[DIR_TX], !belowMid[DIR_TX]};
  assign irq    = irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= 8'hFF;
      dmaEnQ <= 1'b0;
      maskQ  <= 4'h0;
      lastQ  <= 4'h0;
      irqQ   <= 1'b0;
      for (int d = 0; d < NDIR; d++) begin
        startQ[d] <= rstStart(d);
        midQ[d]   <= rstMid(d);
        endQ[d]   <= rstEnd(d);
      end
    end else begin
      if (regWrEn && grp == GRP_GLOBAL) begin
        case (regAddr[1:0])
          2'd0:    ctrlQ  <= regWrData[7:0];
          2'd1:    dmaEnQ <= regWrData[0];
          2'd2:    maskQ  <= regWrData[3:0];
          default: ;
        endcase
      end
      for (int d = 0; d < NDIR; d++) begin
        if (regWrEn && regAddr[3:2] == 2'(d + 1)) begin
          case (regAddr[1:0])
            2'd0:    startQ[d] <= regWrData[AW-1:0];
            2'd1:    midQ[d]   <= regWrData[AW-1:0];
            2'd2:    endQ[d]   <= regWrData[AW-1:0];
            default: ;
          endcase
        end
      end
      irqQ  <= !holdEng && |((status ^ lastQ) & maskQ);
      lastQ <= holdEng ? 4'h0 : status;
    end
  end

  always_comb begin
    regRdData = 32'h0;
    case (grp)
      GRP_GLOBAL: begin
        case (regAddr[1:0])
          2'd0:    regRdData = 32'(ctrlQ);
          2'd1:    regRdData = 32'(dmaEnQ);
          2'd2:    regRdData = 32'(maskQ);
          default: regRdData = 32'(status);
        endcase
      end
      GRP_TX, GRP_RX: begin
        case (regAddr[1:0])
          2'd0:    regRdData = 32'(startQ[grp == GRP_RX]);
          2'd1:    regRdData = 32'(midQ[grp == GRP_RX]);
          2'd2:    regRdData = 32'(endQ[grp == GRP_RX]);
          default: regRdData = 32'(curAddr[grp == GRP_RX]);
        endcase
      end
      default: regRdData = 32'h0;
    endcase
  end
endmodule

// File: rtl/hdma_lane_pack.sv
module hdma_lane_pack #(
  parameter int LANES  = 2,
  parameter int WORD_W = 32,
  parameter int CH_W   = 1
) (
  input  logic [CH_W-1:0]     laneChan,
  input  logic [7:0]          laneByte,
  input  logic                laneFill,
  output logic [WORD_W-1:0]   laneData,
  output logic [WORD_W/8-1:0] laneBe
);
  localparam int NBYTE = WORD_W / 8;
  logic [7:0] putByte;

  assign putByte = laneFill ? 8'hFF : laneByte;

  for (genvar l = 0; l < NBYTE; l++) begin : g_lane
    if (l < LANES) begin : g_used
      assign laneBe[l] = (laneChan == CH_W'(l));
    end else begin : g_spare
      assign laneBe[l] = 1'b0;
    end
    assign laneData[8*l +: 8] = laneBe[l] ? putByte : 8'h00;
  end
endmodule

// File: rtl/hdma_ring_addr.sv
module hdma_ring_addr
  import hdma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TX_WORDS = 512,
  parameter int RX_WORDS = 128,
  parameter int LANES    = 2,
  localparam int CH_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              tickTx,
  input  logic              tickRx,
  output logic [ADDR_W-1:0] txAddr,
  output logic [ADDR_W-1:0] rxAddr,
  output logic [3:0]        halfStatus,
  output logic              irq,
  input  logic [CH_W-1:0]   laneChan,
  input  logic [7:0]        laneByte,
  input  logic              laneFill,
  output logic [31:0]       laneData,
  output logic [3:0]        laneBe
);
  ringStb_t          dirStb  [NDIR];
  logic [ADDR_W-1:0] curAddr [NDIR];
  logic [ADDR_W-1:0] startPtr[NDIR];
  logic [ADDR_W-1:0] endPtr  [NDIR];

  hdma_ring_ctrl #(
    .AW(ADDR_W), .TX_WORDS(TX_WORDS), .RX_WORDS(RX_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .tick({tickRx, tickTx}),
    .curAddr(curAddr), .dirStb(dirStb),
    .startPtr(startPtr), .endPtr(endPtr),
    .status(halfStatus), .irq(irq)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_ring
    localparam logic [ADDR_W-1:0] ST = (d == DIR_TX) ? '0 : ADDR_W'(TX_WORDS);
    hdma_ring_ptr #(.AW(ADDR_W), .RST_START(ST)) u_ptr (
      .clk(clk), .rstN(rstN), .stb(dirStb[d]),
      .startPtr(startPtr[d]), .endPtr(endPtr[d]), .cur(curAddr[d])
    );
  end

  assign txAddr = curAddr[DIR_TX];
  assign rxAddr = curAddr[DIR_RX];

  hdma_lane_pack #(.LANES(LANES), .WORD_W(32), .CH_W(CH_W)) u_lane (
    .laneChan(laneChan), .laneByte(laneByte), .laneFill(laneFill),
    .laneData(laneData), .laneBe(laneBe)
  );
endmodule

// File: rtl/hdma_ring_chk.sv
module hdma_ring_chk
  import hdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CH_W = 1
) (
  input logic            clk,
  input logic            rstN,
  input ringStb_t        dirStb  [NDIR],
  input logic [AW-1:0]   curAddr [NDIR],
  input logic [AW-1:0]   startPtr[NDIR],
  input logic [AW-1:0]   endPtr  [NDIR],
  input logic [CH_W-1:0] laneChan,
  input logic            laneFill,
  input logic [31:0]     laneData
);
  for (genvar d = 0; d < NDIR; d++) begin : g_chk
    AST_RELOAD_PARKS: assert property (@(posedge clk) disable iff (!rstN)
      dirStb[d].reload |=> curAddr[d] == $past(startPtr[d])); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (!dirStb[d].reload && dirStb[d].advance && curAddr[d] != endPtr[d])
        |=> curAddr[d] == $past(curAddr[d]) + 1'b1); // R3
    AST_WRAP_START: assert property (@(posedge clk) disable iff (!rstN)
      (!dirStb[d].reload && dirStb[d].advance && curAddr[d] == endPtr[d])
        |=> curAddr[d] == $past(startPtr[d])); // R4
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rstN)
      (!dirStb[d].reload && !dirStb[d].advance) |=> $stable(curAddr[d])); // R5
  end

  AST_LANE_ISOLATE: assert property (@(posedge clk) disable iff (!rstN)
    (laneChan == '0) |-> laneData[31:8] == 24'h0); // R9
  AST_FILL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    laneFill |-> laneData[8*laneChan +: 8] == 8'hFF); // R10
endmodule

bind hdma_ring_addr hdma_ring_chk #(.AW(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .dirStb(dirStb), .curAddr(curAddr),
  .startPtr(startPtr), .endPtr(endPtr),
  .laneChan(laneChan), .laneFill(laneFill), .laneData(laneData)
);

// File: tb/hdma_ring_addr_bench.sv
module hdma_ring_addr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [3:0]    regAddr = 4'h0;
  logic [31:0]   regWrData = 32'h0;
  logic [31:0]   regRdData;
  logic          tickTx = 1'b0;
  logic          tickRx = 1'b0;
  logic [AW-1:0] txAddr;
  logic [AW-1:0] rxAddr;
  logic [3:0]    halfStatus;
  logic          irq;
  logic [0:0]    laneChan = 1'b0;
  logic [7:0]    laneByte = 8'h00;
  logic          laneFill = 1'b0;
  logic [31:0]   laneData;
  logic [3:0]    laneBe;

  int checks = 0;
  int failures = 0;
  int irqCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdma_ring_addr u_hdma_ring_addr (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .tickTx(tickTx), .tickRx(tickRx), .txAddr(txAddr), .rxAddr(rxAddr),
    .halfStatus(halfStatus), .irq(irq),
    .laneChan(laneChan), .laneByte(laneByte), .laneFill(laneFill),
    .laneData(laneData), .laneBe(laneBe)
  );

  always @(posedge clk) if (rstN && irq) irqCount++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] v);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic pulseTx(input int n);
    tickTx = 1'b1;
    repeat (n) @(negedge clk);
    tickTx = 1'b0;
  endtask

  task automatic pulseRx(input int n);
    tickRx = 1'b1;
    repeat (n) @(negedge clk);
    tickRx = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 txAddr", 32'(txAddr), 32'd0);
    check("R1 rxAddr", 32'(rxAddr), 32'd512);
    check("R1 irq", 32'(irq), 32'd0);
    check("R6 status at reset", 32'(halfStatus), 32'hA);
    regRead(4'd0, v);  check("R1 control", v, 32'hFF);
    regRead(4'd6, v);  check("R1 tx end", v, 32'd511);
    regRead(4'd5, v);  check("R1 tx mid", v, 32'd255);
    regRead(4'd8, v);  check("R1 rx start", v, 32'd512);
    regRead(4'd9, v);  check("R1 rx mid", v, 32'd575);
  endtask

  task automatic tHold();
    regWrite(4'd2, 32'hF);
    regWrite(4'd1, 32'h1);
    tickTx = 1'b1; tickRx = 1'b1;
    repeat (4) @(negedge clk);
    tickTx = 1'b0; tickRx = 1'b0;
    check("R2 held tx", 32'(txAddr), 32'd0);
    check("R2 held rx", 32'(rxAddr), 32'd512);
    check("R7 no irq while held", 32'(irqCount), 32'd0);
  endtask

  task automatic tRelease();
    logic [31:0] v;
    regWrite(4'd0, 32'h40);
    settle();
    check("R7 first report after release", 32'(irqCount), 32'd1);
    regRead(4'd0, v); check("R2 control released", v, 32'h40);
  endtask

  task automatic tAdvance();
    logic [31:0] v;
    pulseTx(5);
    check("R3 tx after 5", 32'(txAddr), 32'd5);
    check("R3 rx ignores tx strobe", 32'(rxAddr), 32'd512);
    pulseRx(3);
    check("R3 rx after 3", 32'(rxAddr), 32'd515);
    check("R3 tx ignores rx strobe", 32'(txAddr), 32'd5);
    regRead(4'd7, v);  check("R11 tx readback", v, 32'd5);
    regRead(4'd11, v); check("R11 rx readback", v, 32'd515);
    pulseTx(249);
    settle();
    check("R6 below tx mid", 32'(halfStatus), 32'hA);
    check("R7 no irq below mid", 32'(irqCount), 32'd1);
    pulseTx(1);
    check("R3 tx at mid", 32'(txAddr), 32'd255);
    check("R6 tx upper half", 32'(halfStatus), 32'h9);
    settle();
    check("R7 tx mid crossing", 32'(irqCount), 32'd2);
  endtask

  task automatic tWrap();
    pulseTx(256);
    check("R4 tx at end", 32'(txAddr), 32'd511);
    pulseTx(1);
    check("R4 tx wrap", 32'(txAddr), 32'd0);
    settle();
    check("R6 tx wrap status", 32'(halfStatus), 32'hA);
    check("R7 tx wrap irq", 32'(irqCount), 32'd3);
  endtask

  task automatic tRxRing();
    pulseRx(60);
    check("R3 rx at mid", 32'(rxAddr), 32'd575);
    check("R6 rx upper half", 32'(halfStatus), 32'h6);
    settle();
    check("R7 rx mid irq", 32'(irqCount), 32'd4);
    pulseRx(64);
    check("R4 rx at end", 32'(rxAddr), 32'd639);
    pulseRx(1);
    check("R4 rx wrap", 32'(rxAddr), 32'd512);
    settle();
    check("R7 rx wrap irq", 32'(irqCount), 32'd5);
  endtask

  task automatic tDisable();
    regWrite(4'd1, 32'h0);
    pulseTx(7);
    pulseRx(7);
    check("R5 tx frozen", 32'(txAddr), 32'd0);
    check("R5 rx frozen", 32'(rxAddr), 32'd512);
    regWrite(4'd1, 32'h1);
  endtask

  task automatic tMask();
    regWrite(4'd2, 32'hC);
    pulseTx(255);
    settle();
    check("R6 masked change visible", 32'(halfStatus), 32'h9);
    check("R8 masked no irq", 32'(irqCount), 32'd5);
    regWrite(4'd2, 32'hF);
    settle();
    check("R8 no late irq on unmask", 32'(irqCount), 32'd5);
    pulseTx(257);
    settle();
    check("R8 unmasked irq", 32'(irqCount), 32'd6);
  endtask

  task automatic tSmallRing();
    logic [31:0] v;
    regWrite(4'd0, 32'hFF);
    regWrite(4'd4, 32'd10);
    regWrite(4'd5, 32'd12);
    regWrite(4'd6, 32'd13);
    @(negedge clk);
    check("R2 reload to new start", 32'(txAddr), 32'd10);
    regWrite(4'd0, 32'h40);
    settle();
    check("R7 report after re-release", 32'(irqCount), 32'd7);
    pulseTx(1); check("R3 small ring 11", 32'(txAddr), 32'd11);
    check("R6 small ring below mid", 32'(halfStatus[1:0]), 32'h2);
    pulseTx(1); check("R3 small ring 12", 32'(txAddr), 32'd12);
    check("R6 small ring at mid", 32'(halfStatus[1:0]), 32'h1);
    pulseTx(1); regRead(4'd7, v); check("R11 small ring 13", v, 32'd13);
    pulseTx(1); check("R4 small ring wrap", 32'(txAddr), 32'd10);
  endtask

  task automatic tLane();
    laneChan = 1'b0; laneByte = 8'hA5; laneFill = 1'b0; #1;
    check("R9 lane0 data", laneData, 32'h0000_00A5);
    check("R9 lane0 be", 32'(laneBe), 32'h1);
    laneChan = 1'b1; #1;
    check("R9 lane1 data", laneData, 32'h0000_A500);
    check("R9 lane1 be", 32'(laneBe), 32'h2);
    laneFill = 1'b1; #1;
    check("R10 lane1 fill", laneData, 32'h0000_FF00);
    laneChan = 1'b0; #1;
    check("R10 lane0 fill", laneData, 32'h0000_00FF);
    laneFill = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tHold();
    tRelease();
    tAdvance();
    tWrap();
    tRxRing();
    tDisable();
    tMask();
    tSmallRing();
    tLane();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule